// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This unit is the data-path calculator of a small 8-bit processor core. Each cycle it takes two byte operands (the second may carry an immediate), a five-bit operation code and the current status byte. It returns the byte result, the next status byte and a write-enable that tells the register file whether to store the result. Every byte operation is combinational and finishes in the cycle it is issued. Each operation follows its own rule for which flags it rewrites and which it passes through.

A 16-bit add or subtract of a small immediate on a register pair takes two cycles. In the first cycle the caller presents the low byte of the pair. The unit returns the low result and leaves the status byte untouched. In the second cycle the caller presents the high byte. The unit then returns the high result and the status flags for the full 16-bit value. The operation code in that second cycle is ignored.

Top module: `alu_core`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Bits 6 and 7 of `sreg_i` always pass through to `sreg_o` unchanged. Operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, AND=4, OR=5, XOR=6, INV=7, NEG=8, SETM=9, CLRM=10, INC=11, DEC=12, TEST=13, ZERO=14, CMP=15, CMPC=16, WADD=17, WSUB=18.
- R2: ADD and ADDC return a+b (+C for ADDC), mod 256. C is the carry out of bit 7. H is the carry out of bit 3. V is two's-complement overflow. N is the result's bit 7. Z is set when the result is zero.
- R3: SUB, SUBC, CMP and CMPC compute a-b (-C for the carry forms), mod 256. C and H are the borrows out of bit 7 and bit 3. V is signed overflow, and N and Z follow the result. For SUBC and CMPC, Z is cleared when the result is nonzero and otherwise keeps its value from `sreg_i`.
- R4: CMP and CMPC drive `wr_en_o` low. Every other defined byte operation drives it high.
- R5: AND, OR, XOR, SETM (a OR b), TEST (result a) and ZERO (result 0) update Z and N and force V to 0. C and H are unchanged.
- R6: CLRM returns a AND (0xFF minus b), with the same flag rule as R5.
- R7: INV returns 0xFF minus a. It sets C to 1 and V to 0 and updates Z and N. H is unchanged.
- R8: NEG returns 0x00 minus a. It updates C (set when a is nonzero), H (borrow out of bit 3), V (set only for a=0x80), N and Z.
- R9: INC and DEC return a+1 and a-1. V is set only on 0x7F to 0x80 for INC, and only on 0x80 to 0x7F for DEC. Z and N follow the result. C and H are unchanged.
- R10: Whenever N or V is updated, S equals N XOR V.
- R11: WADD and WSUB take two cycles. In the issue cycle, `res_o` is the low byte of the 16-bit result, `sreg_o` equals `sreg_i`, and `word_hi_o` is 0. In the next cycle, `word_hi_o` is 1, `opa_i` carries the high byte and `res_o` is the high byte of the result. `op_i` is ignored in that cycle.
- R12: In the second word cycle, the immediate is `opb_i[5:0]` and `opb_i[7:6]` is ignored. Z means the 16-bit result is zero. C is the carry or borrow out of bit 15. V is 16-bit signed overflow. N is bit 15, and S equals N XOR V. H is unchanged.
- R13: While reset is held, `word_hi_o` is 0, and any word operation in flight is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | First operand; register-pair byte for word ops |
| opb_i | input | 8 | Second operand or immediate |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Result byte |
| sreg_o | output | 8 | Next status byte |
| wr_en_o | output | 1 | Result should be written back |
| word_hi_o | output | 1 | Second cycle of a word operation |

## Verification
The assertions assume `op_i` holds a defined, non-X code whenever it is sampled, except in the second word cycle, where it may be anything. They also assume the status inputs are known at each clock edge. The stimulus draws operation codes only from the defined set of byte operations. It issues word operations as complete two-cycle pairs and fills the ignored opcode of the second cycle with random values. The corner cases are directed: overflow edges at 0x7F and 0x80, carry chains through 0xFF and 0xFFFF, and the sticky-zero inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_INV  = 5'd7,
    OP_NEG  = 5'd8,  OP_SETM = 5'd9,  OP_CLRM = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_TEST = 5'd13, OP_ZERO = 5'd14, OP_CMP  = 5'd15,
    OP_CMPC = 5'd16, OP_WADD = 5'd17, OP_WSUB = 5'd18
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          co_o,
  output logic          hc_o,
  output logic          ov_o
);
  localparam int HB = DW / 2;

  logic [DW-1:0] bx;
  logic          ci;
  logic [DW:0]   full;
  logic [HB:0]   half;

  // subtract as a + ~b + ~borrow; carries invert into borrows
  assign bx   = sub_i ? ~b_i : b_i;
  assign ci   = sub_i ^ cin_i;
  assign full = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, ci};
  assign half = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};

  assign res_o = full[DW-1:0];
  assign co_o  = full[DW] ^ sub_i;
  assign hc_o  = half[HB] ^ sub_i;
  assign ov_o  = (a_i[DW-1] == bx[DW-1]) && (full[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:          res_o = a_i & b_i;
      OP_OR, OP_SETM:  res_o = a_i | b_i;
      OP_XOR:          res_o = a_i ^ b_i;
      OP_INV:          res_o = ~a_i;
      OP_CLRM:         res_o = a_i & ~b_i;
      OP_TEST:         res_o = a_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_word.sv
module alu_word #(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          sub_i,
  input  logic [DW-1:0] a_i,
  input  logic [KW-1:0] k_i,
  output logic          hi_o,
  output logic [DW-1:0] res_o,
  output logic          z_o,
  output logic          c_o,
  output logic          n_o,
  output logic          v_o
);
  logic          hi_q, sub_q, cy_q, lz_q;
  logic [DW:0]   lo_sum;
  logic [DW-1:0] hi_sum;
  logic          top_a, top_r;

  assign lo_sum = sub_i ? ({1'b0, a_i} - {{(DW+1-KW){1'b0}}, k_i})
                        : ({1'b0, a_i} + {{(DW+1-KW){1'b0}}, k_i});
  assign hi_sum = sub_q ? (a_i - {{(DW-1){1'b0}}, cy_q})
                        : (a_i + {{(DW-1){1'b0}}, cy_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      sub_q <= 1'b0;
      cy_q  <= 1'b0;
      lz_q  <= 1'b0;
    end else begin
      hi_q <= go_i;
      if (go_i) begin
        sub_q <= sub_i;
        cy_q  <= lo_sum[DW];
        lz_q  <= (lo_sum[DW-1:0] == '0);
      end
    end
  end

  assign top_a = a_i[DW-1];
  assign top_r = hi_sum[DW-1];
  assign hi_o  = hi_q;
  assign res_o = hi_q ? hi_sum : lo_sum[DW-1:0];
  assign z_o   = lz_q && (hi_sum == '0);
  assign n_o   = top_r;
  assign v_o   = sub_q ? (top_a & ~top_r) : (~top_a & top_r);
  assign c_o   = sub_q ? (~top_a & top_r) : (top_a & ~top_r);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [7:0]    sreg_i,
  output logic [DW-1:0] res_o,
  output logic [7:0]    sreg_o,
  output logic          wr_en_o,
  output logic          word_hi_o
);
  localparam int MSB = DW - 1;

  alu_op_e       op;
  logic [DW-1:0] ar_a, ar_b, ar_res, lg_res, wd_res;
  logic          ar_c, ar_sub, ar_co, ar_hc, ar_ov;
  logic          wd_hi, wd_go, wd_z, wd_c, wd_n, wd_v;
  logic          sticky_z;
  logic          unused_imm_hi;

  assign op            = alu_op_e'(op_i);
  assign wd_go         = !wd_hi && (op == OP_WADD || op == OP_WSUB);
  assign unused_imm_hi = ^opb_i[DW-1:KW];

  always_comb begin
    ar_a   = opa_i;
    ar_b   = opb_i;
    ar_c   = 1'b0;
    ar_sub = 1'b0;
    case (op)
      OP_ADDC:          ar_c = sreg_i[FL_C];
      OP_SUB, OP_CMP:   ar_sub = 1'b1;
      OP_SUBC, OP_CMPC: begin ar_sub = 1'b1; ar_c = sreg_i[FL_C]; end
      OP_NEG:           begin ar_a = '0; ar_b = opa_i; ar_sub = 1'b1; end
      OP_INC:           ar_b = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:           begin ar_b = {{(DW-1){1'b0}}, 1'b1}; ar_sub = 1'b1; end
      default:          ;
    endcase
  end

  alu_addsub #(.DW(DW)) u_arith (
    .a_i(ar_a), .b_i(ar_b), .cin_i(ar_c), .sub_i(ar_sub),
    .res_o(ar_res), .co_o(ar_co), .hc_o(ar_hc), .ov_o(ar_ov)
  );

  alu_logic #(.DW(DW)) u_logic (
    .op_i(op), .a_i(opa_i), .b_i(opb_i), .res_o(lg_res)
  );

  alu_word #(.DW(DW), .KW(KW)) u_word (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(wd_go), .sub_i(op == OP_WSUB),
    .a_i(opa_i), .k_i(opb_i[KW-1:0]), .hi_o(wd_hi), .res_o(wd_res),
    .z_o(wd_z), .c_o(wd_c), .n_o(wd_n), .v_o(wd_v)
  );

  // carry-chained subtracts only ever clear Z
  assign sticky_z = (op == OP_SUBC || op == OP_CMPC) ? sreg_i[FL_Z] : 1'b1;

  always_comb begin
    sreg_o  = sreg_i;
    res_o   = '0;
    wr_en_o = 1'b1;
    if (wd_hi) begin
      res_o        = wd_res;
      sreg_o[FL_C] = wd_c;
      sreg_o[FL_Z] = wd_z;
      sreg_o[FL_N] = wd_n;
      sreg_o[FL_V] = wd_v;
      sreg_o[FL_S] = wd_n ^ wd_v;
    end else begin
      case (op)
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG, OP_CMP, OP_CMPC: begin
          res_o        = ar_res;
          sreg_o[FL_C] = ar_co;
          sreg_o[FL_H] = ar_hc;
          sreg_o[FL_Z] = (ar_res == '0) && sticky_z;
          sreg_o[FL_N] = ar_res[MSB];
          sreg_o[FL_V] = ar_ov;
          sreg_o[FL_S] = ar_res[MSB] ^ ar_ov;
          wr_en_o      = !(op == OP_CMP || op == OP_CMPC);
        end
        OP_INC, OP_DEC: begin
          res_o        = ar_res;
          sreg_o[FL_Z] = (ar_res == '0);
          sreg_o[FL_N] = ar_res[MSB];
          sreg_o[FL_V] = ar_ov;
          sreg_o[FL_S] = ar_res[MSB] ^ ar_ov;
        end
        OP_AND, OP_OR, OP_XOR, OP_SETM, OP_CLRM, OP_TEST, OP_ZERO, OP_INV: begin
          res_o        = lg_res;
          sreg_o[FL_Z] = (lg_res == '0);
          sreg_o[FL_N] = lg_res[MSB];
          sreg_o[FL_V] = 1'b0;
          sreg_o[FL_S] = lg_res[MSB];
          if (op == OP_INV) sreg_o[FL_C] = 1'b1;
        end
        OP_WADD, OP_WSUB: res_o = wd_res;
        default:          wr_en_o = 1'b0;
      endcase
    end
  end

  assign word_hi_o = wd_hi;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] op_i,
  input logic [7:0] opa_i,
  input logic [7:0] sreg_i,
  input logic [7:0] sreg_o,
  input logic       wr_en_o,
  input logic       word_hi_o
);
  logic byte_cyc, is_logic, is_word, upd_nv;

  assign byte_cyc = !word_hi_o;
  assign is_logic = op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR ||
                    op_i == OP_SETM || op_i == OP_CLRM || op_i == OP_TEST ||
                    op_i == OP_ZERO;
  assign is_word  = op_i == OP_WADD || op_i == OP_WSUB;
  assign upd_nv   = word_hi_o || (op_i <= OP_CMPC);

  assert_cmp_nowrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && (op_i == OP_CMP || op_i == OP_CMPC) |-> !wr_en_o);

  assert_sticky_z_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && (op_i == OP_SUBC || op_i == OP_CMPC) && !sreg_i[FL_Z] |-> !sreg_o[FL_Z]);

  assert_logic_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && is_logic |-> sreg_o[FL_C] == sreg_i[FL_C] && sreg_o[FL_H] == sreg_i[FL_H] && !sreg_o[FL_V]);

  assert_inv_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && op_i == OP_INV |-> sreg_o[FL_C] && !sreg_o[FL_V]);

  assert_inc_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && op_i == OP_INC |-> sreg_o[FL_V] == (opa_i == 8'h7f));

  assert_sign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_nv |-> sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V]));

  assert_word_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cyc && is_word |-> sreg_o == sreg_i ##1 word_hi_o);

  assert_word_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_hi_o |=> !word_hi_o);

  assert_word_h_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_hi_o |-> sreg_o[FL_H] == sreg_i[FL_H]);
endmodule

bind alu_core alu_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .opa_i(opa_i),
  .sreg_i(sreg_i), .sreg_o(sreg_o), .wr_en_o(wr_en_o), .word_hi_o(word_hi_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  import alu_pkg::*;

  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opa = '0, opb = '0, sreg = '0;
  logic [7:0] res, sreg_out;
  logic       wr_en, word_hi;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  alu_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_i(opa), .opb_i(opb),
    .sreg_i(sreg), .res_o(res), .sreg_o(sreg_out), .wr_en_o(wr_en),
    .word_hi_o(word_hi)
  );

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int sx(logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  function automatic string tag_of(alu_op_e o);
    case (o)
      OP_ADD, OP_ADDC:          return "R2";
      OP_SUB, OP_SUBC, OP_CMP, OP_CMPC: return "R3";
      OP_CLRM:                  return "R6";
      OP_INV:                   return "R7";
      OP_NEG:                   return "R8";
      OP_INC, OP_DEC:           return "R9";
      default:                  return "R5";
    endcase
  endfunction

  // {we, result, status}
  function automatic logic [16:0] model(alu_op_e o, logic [7:0] a, logic [7:0] b, logic [7:0] s);
    logic [7:0] r, so;
    logic       we;
    int         t, h, sv, ci;
    so = s; we = 1'b1; r = '0;
    case (o)
      OP_ADD, OP_ADDC: begin
        ci = (o == OP_ADDC) ? int'(s[0]) : 0;
        t = int'(a) + int'(b) + ci; r = t[7:0];
        h = int'(a % 16) + int'(b % 16) + ci;
        sv = sx(a) + sx(b) + ci;
        so[0] = t > 255; so[5] = h > 15; so[3] = sv > 127 || sv < -128;
        so[2] = r[7]; so[1] = r == 0;
      end
      OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG: begin
        logic [7:0] x, y;
        x = (o == OP_NEG) ? 8'h00 : a;
        y = (o == OP_NEG) ? a : b;
        ci = (o == OP_SUBC || o == OP_CMPC) ? int'(s[0]) : 0;
        t = int'(x) - int'(y) - ci; r = t[7:0];
        h = int'(x % 16) - int'(y % 16) - ci;
        sv = sx(x) - sx(y) - ci;
        so[0] = t < 0; so[5] = h < 0; so[3] = sv > 127 || sv < -128;
        so[2] = r[7];
        so[1] = (r == 0) && ((o == OP_SUBC || o == OP_CMPC) ? s[1] : 1'b1);
        we = !(o == OP_CMP || o == OP_CMPC);
      end
      OP_INC, OP_DEC: begin
        r = (o == OP_INC) ? a + 8'd1 : a - 8'd1;
        so[3] = (o == OP_INC) ? (a == 8'h7f) : (a == 8'h80);
        so[2] = r[7]; so[1] = r == 0;
      end
      default: begin
        case (o)
          OP_AND:          r = a & b;
          OP_OR, OP_SETM:  r = a | b;
          OP_XOR:          r = a ^ b;
          OP_CLRM:         r = a & (8'hff - b);
          OP_TEST:         r = a;
          OP_INV:          r = 8'hff - a;
          default:         r = 8'h00;
        endcase
        so[3] = 1'b0; so[2] = r[7]; so[1] = r == 0;
        if (o == OP_INV) so[0] = 1'b1;
      end
    endcase
    so[4] = so[2] ^ so[3];
    return {we, r, so};
  endfunction

  task automatic run_byte(alu_op_e o, logic [7:0] a, logic [7:0] b, logic [7:0] s);
    logic [16:0] e;
    string       tg;
    @(negedge clk);
    op = o; opa = a; opb = b; sreg = s;
    #2;
    e = model(o, a, b, s);
    tg = tag_of(o);
    check({tg, " result"}, res, e[15:8]);
    check({tg, " status"}, sreg_out, e[7:0]);
    check("R4 write enable", wr_en, e[16]);
    check("R10 sign", sreg_out[4], sreg_out[2] ^ sreg_out[3]);
    check("R11 no word phase", word_hi, 0);
  endtask

  task automatic run_word(bit sub, logic [15:0] w, logic [7:0] b, logic [7:0] s);
    int          k, t, sv;
    logic [15:0] r;
    logic [7:0]  so;
    k = int'(b[5:0]);
    t  = sub ? int'(w) - k : int'(w) + k;
    r  = t[15:0];
    sv = (w[15] ? int'(w) - 65536 : int'(w)) + (sub ? -k : k);
    so = s;
    so[0] = sub ? (t < 0) : (t > 65535);
    so[3] = sv > 32767 || sv < -32768;
    so[2] = r[15]; so[1] = r == 0; so[4] = so[2] ^ so[3];
    @(negedge clk);
    op = sub ? OP_WSUB : OP_WADD; opa = w[7:0]; opb = b; sreg = s;
    #2;
    check("R11 low byte", res, r[7:0]);
    check("R11 status held", sreg_out, s);
    check("R11 first phase", word_hi, 0);
    @(negedge clk);
    op = 5'($urandom_range(31)); opa = w[15:8];
    #2;
    check("R11 second phase", word_hi, 1);
    check("R11 high byte", res, r[15:8]);
    check("R12 word status", sreg_out, so);
    check("R11 write", wr_en, 1);
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R13 reset
    @(negedge clk);
    op = OP_WADD;
    @(negedge clk);
    check("R13 reset word phase", word_hi, 0);
    op = OP_ADD;
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R13 after release", word_hi, 0);

    // directed corners
    run_byte(OP_ADD, 8'h7f, 8'h01, 8'h00);
    run_byte(OP_ADD, 8'hff, 8'h01, 8'hc0);
    run_byte(OP_ADDC, 8'h0f, 8'h00, 8'h01);
    run_byte(OP_SUB, 8'h80, 8'h01, 8'h00);
    run_byte(OP_SUBC, 8'h05, 8'h04, 8'h01);   // R3 zero result, Z was 0 stays 0
    run_byte(OP_SUBC, 8'h05, 8'h04, 8'h03);   // R3 zero result, Z kept 1
    run_byte(OP_CMPC, 8'h10, 8'h10, 8'h00);   // R3 sticky
    run_byte(OP_CMP, 8'h10, 8'h20, 8'h00);    // R4
    run_byte(OP_NEG, 8'h80, 8'h00, 8'h00);    // R8
    run_byte(OP_NEG, 8'h00, 8'h00, 8'h3f);
    run_byte(OP_NEG, 8'h10, 8'h00, 8'h00);
    run_byte(OP_INC, 8'h7f, 8'h00, 8'h21);    // R9
    run_byte(OP_INC, 8'hff, 8'h00, 8'h00);
    run_byte(OP_DEC, 8'h80, 8'h00, 8'h21);
    run_byte(OP_DEC, 8'h01, 8'h00, 8'h00);
    run_byte(OP_INV, 8'hff, 8'h00, 8'h28);    // R7
    run_byte(OP_CLRM, 8'hff, 8'h0f, 8'h21);   // R6
    run_byte(OP_ZERO, 8'h55, 8'haa, 8'h29);   // R5
    run_byte(OP_TEST, 8'h80, 8'h00, 8'h08);
    run_word(1'b0, 16'hffff, 8'h01, 8'h20);   // R12 carry and zero
    run_word(1'b1, 16'h0000, 8'h01, 8'h00);
    run_word(1'b0, 16'h7fff, 8'h01, 8'h00);
    run_word(1'b1, 16'h8000, 8'h01, 8'h00);
    run_word(1'b0, 16'h00ff, 8'hc1, 8'h00);   // R12 upper immediate bits ignored
    run_word(1'b1, 16'h0100, 8'h3f, 8'hff);

    for (int i = 0; i < 3000; i++)
      run_byte(alu_op_e'($urandom_range(16)), 8'($urandom), 8'($urandom), 8'($urandom));
    for (int i = 0; i < 400; i++)
      run_word(1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom));
    run_byte(OP_ADD, 8'h01, 8'h02, 8'h00);   // R1 back to byte ops after word

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule